// File: doc/BRIEF.md
# Tap-Selected Vote Input Filter

This block cleans up one noisy or bouncing input line. The raw pin first passes through a two-stage flip-flop synchroniser. Each sample strobe then shifts the synchronised level into a short history register. The filtered output goes high only when every sample in the active window is 1, and goes low only when every sample is 0. For any mixed window it keeps its level. A 3-bit mode input chooses either a plain registered path or one of four pairs of window depth and sample rate.

The slow sample strobes are not made by a prescaler inside each pin. Every pin receives the same free-running system counter. For each of three tap inputs (P, Q, R), the block watches the counter bit that the tap names and fires a strobe on that bit's 0-to-1 transition. A small two-state machine (`LVL_LO`, `LVL_HI`) holds the output level. Its transition RISE (`LVL_LO` to `LVL_HI`) happens on an all-ones window, or on a synchronised 1 in pass mode. Its transition FALL (`LVL_HI` to `LVL_LO`) happens on an all-zeros window, or on a synchronised 0 in pass mode. In every other case it stays in its state. When the mode changes, the history is preloaded so that it does not mix samples taken under two configurations.

Top module: `sel_vote_filter`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after its release with `pin_in` low, `filt_out` is 0.
- R2: Modes 000, 001, 010 and 011 do no voting: `filt_out` equals `pin_in` as it was three rising clock edges earlier (two synchroniser stages plus the output register).
- R3: Mode 100 votes 2-of-2 with a sample on every clock. A `pin_in` pulse one cycle wide never reaches `filt_out`. A level held for two cycles does, so a pin that toggles every second clock is still followed.
- R4: Mode 101 votes 2-of-2 on samples taken at the P strobe.
- R5: Mode 110 votes 3-of-3 on samples taken at the Q strobe.
- R6: Mode 111 votes 4-of-4 on samples taken at the R strobe.
- R7: In the voting modes, `filt_out` becomes 1 only when the newest N samples are all 1, and becomes 0 only when they are all 0. Here N is 2, 3 or 4 according to the mode. A mixed window keeps the previous output.
- R8: A tap strobe fires in the cycle where `sys_count[tap]` is 1 and was 0 on the previous clock. A tap index at or above the counter width never fires, so the output of a mode that uses that tap keeps its level.
- R9: A change on `mode_sel` fills the whole history with the current synchronised level. A strobe in that same cycle is dropped. The new mode controls voting from the next clock on.
- R10: The history shifts only when the strobe chosen by the active voting mode fires. Pin activity between strobes has no effect on `filt_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Raw, asynchronous pin level |
| mode_sel | input | 3 | Filter mode: 000-011 pass, 100 2-of-2 every clock, 101 2-of-2 on P, 110 3-of-3 on Q, 111 4-of-4 on R |
| sys_count | input | CNT_W (24) | Shared free-running system counter |
| tap_p | input | $clog2(CNT_W) (5) | Counter bit index for the P strobe |
| tap_q | input | $clog2(CNT_W) (5) | Counter bit index for the Q strobe |
| tap_r | input | $clog2(CNT_W) (5) | Counter bit index for the R strobe |
| filt_out | output | 1 | Filtered level |

## Verification
A mode change and a sample strobe can fall in the same clock, and the design must let the history preload win over the shift. The bench provokes this by switching modes while in mode 100, where a strobe fires on every clock, and by switching in and out of the tapped modes at random points of the counter. A behavioural model, built on a sample queue, applies the preload-first rule. The design's output is compared with that model on every clock, so a dropped preload or a stray shift appears as a mismatch a few cycles later.

// File: rtl/svf_pkg.sv
package svf_pkg;

    typedef enum logic [2:0] {
        MD_RAW   = 3'b000,
        MD_RSV1  = 3'b001,
        MD_RSV2  = 3'b010,
        MD_RSV3  = 3'b011,
        MD_FAST2 = 3'b100,
        MD_P2    = 3'b101,
        MD_Q3    = 3'b110,
        MD_R4    = 3'b111
    } flt_mode_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    typedef enum logic [1:0] {
        SRC_EVERY = 2'd0,
        SRC_P     = 2'd1,
        SRC_Q     = 2'd2,
        SRC_R     = 2'd3
    } strobe_src_e;

    typedef struct packed {
        logic        pass;
        logic [2:0]  depth;
        strobe_src_e src;
    } mode_cfg_t;

    // Mode decode: pass flag, vote depth and strobe source.
    function automatic mode_cfg_t decode_mode(input flt_mode_e m);
        mode_cfg_t c;
        c = '{pass: 1'b1, depth: 3'd0, src: SRC_EVERY};
        case (m)
            MD_FAST2: c = '{pass: 1'b0, depth: 3'd2, src: SRC_EVERY};
            MD_P2:    c = '{pass: 1'b0, depth: 3'd2, src: SRC_P};
            MD_Q3:    c = '{pass: 1'b0, depth: 3'd3, src: SRC_Q};
            MD_R4:    c = '{pass: 1'b0, depth: 3'd4, src: SRC_R};
            default:  c = '{pass: 1'b1, depth: 3'd0, src: SRC_EVERY};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/svf_sync.sv
module svf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/svf_tap_strobe.sv
module svf_tap_strobe #(
    parameter int CNT_W  = 24,
    parameter int N_TAPS = 3,
    parameter int IDX_W  = $clog2(CNT_W)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CNT_W-1:0]                 sys_count,
    input  logic [N_TAPS-1:0][IDX_W-1:0]     tap_sel,
    output logic [N_TAPS-1:0]                strobe
);
    localparam logic [IDX_W:0] CNT_LIM = (IDX_W+1)'(CNT_W);

    logic [N_TAPS-1:0] bit_now;
    logic [N_TAPS-1:0] bit_prev;

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        // Out-of-range index reads as constant 0 and never strobes.
        assign bit_now[g] = ({1'b0, tap_sel[g]} < CNT_LIM) ? sys_count[tap_sel[g]] : 1'b0;
        assign strobe[g]  = bit_now[g] & ~bit_prev[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_prev <= '0;
        end else begin
            bit_prev <= bit_now;
        end
    end
endmodule

// File: rtl/svf_vote_hist.sv
module svf_vote_hist #(
    parameter int HIST_D = 4,
    parameter int DEP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              shift_en,
    input  logic              preload,
    input  logic [DEP_W-1:0]  depth,
    output logic [HIST_D-1:0] hist,
    output logic              all_one,
    output logic              all_zero
);
    logic [HIST_D-1:0] win_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (preload) begin
            hist <= {HIST_D{sample}};
        end else if (shift_en) begin
            hist <= {hist[HIST_D-2:0], sample};
        end
    end

    always_comb begin
        for (int i = 0; i < HIST_D; i++) begin
            win_mask[i] = (i < int'(depth));
        end
    end

    assign all_one  = ((hist | ~win_mask) == '1) && (win_mask != '0);
    assign all_zero = ((hist & win_mask) == '0) && (win_mask != '0);
endmodule

// File: rtl/sel_vote_filter.sv
module sel_vote_filter
    import svf_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int HIST_D      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [2:0]       mode_sel,
    input  logic [CNT_W-1:0] sys_count,
    input  logic [IDX_W-1:0] tap_p,
    input  logic [IDX_W-1:0] tap_q,
    input  logic [IDX_W-1:0] tap_r,
    output logic             filt_out
);
    localparam int N_TAPS = 3;

    flt_mode_e          mode_q;
    mode_cfg_t          cfg;
    logic               mode_chg;
    logic               pass_mode;
    logic               sync_lvl;
    logic [N_TAPS-1:0]  tap_strobe;
    logic               sel_strobe;
    logic               shift_en;
    logic [HIST_D-1:0]  hist;
    logic               all_one;
    logic               all_zero;
    lvl_state_e         state_q;
    lvl_state_e         state_d;

    svf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_lvl)
    );

    svf_tap_strobe #(.CNT_W(CNT_W), .N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_count (sys_count),
        .tap_sel   ({tap_r, tap_q, tap_p}),
        .strobe    (tap_strobe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_RAW;
        end else begin
            mode_q <= flt_mode_e'(mode_sel);
        end
    end

    assign mode_chg  = (mode_sel != mode_q);
    assign cfg       = decode_mode(mode_q);
    assign pass_mode = cfg.pass;

    always_comb begin
        unique case (cfg.src)
            SRC_EVERY: sel_strobe = 1'b1;
            SRC_P:     sel_strobe = tap_strobe[0];
            SRC_Q:     sel_strobe = tap_strobe[1];
            SRC_R:     sel_strobe = tap_strobe[2];
        endcase
    end

    assign shift_en = sel_strobe & ~pass_mode;

    svf_vote_hist #(.HIST_D(HIST_D), .DEP_W(3)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (sync_lvl),
        .shift_en (shift_en),
        .preload  (mode_chg),
        .depth    (cfg.depth),
        .hist     (hist),
        .all_one  (all_one),
        .all_zero (all_zero)
    );

    // Output level state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LVL_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // RISE / FALL transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LO: if (pass_mode ? sync_lvl : all_one)   state_d = LVL_HI;
            LVL_HI: if (pass_mode ? !sync_lvl : all_zero) state_d = LVL_LO;
        endcase
    end

    // Output process
    always_comb begin
        filt_out = (state_q == LVL_HI);
    end
endmodule

// File: rtl/sel_vote_filter_chk.sv
module sel_vote_filter_chk #(
    parameter int HIST_D = 4,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              filt_out,
    input logic              pass_mode,
    input logic              sync_lvl,
    input logic [2:0]        mode_q,
    input logic              mode_chg,
    input logic              shift_en,
    input logic [HIST_D-1:0] hist,
    input logic              all_one,
    input logic              all_zero,
    input logic [2:0]        tap_strobe,
    input logic [IDX_W-1:0]  tap_p,
    input logic [IDX_W-1:0]  tap_q,
    input logic [IDX_W-1:0]  tap_r
);
    // R2
    pass_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pass_mode) |-> (filt_out == $past(sync_lvl)));

    // R7
    change_needs_unanimity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pass_mode) && (filt_out != $past(filt_out)))
            |-> (filt_out ? $past(all_one) : $past(all_zero)));

    // R3
    fast_no_double_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'b100) && ($past(mode_q) == 3'b100) && ($past(mode_q, 2) == 3'b100)
            && ($past(filt_out) != $past(filt_out, 2)))
            |-> (filt_out == $past(filt_out)));

    // R9
    preload_fills_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_chg) |-> (hist == {HIST_D{$past(sync_lvl)}}));

    // R10
    hist_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(shift_en) && !$past(mode_chg)) |-> $stable(hist));

    // R8
    p_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tap_strobe[0]) && $stable(tap_p)) |-> !tap_strobe[0]);

    // R8
    q_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tap_strobe[1]) && $stable(tap_q)) |-> !tap_strobe[1]);

    // R8
    r_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tap_strobe[2]) && $stable(tap_r)) |-> !tap_strobe[2]);
endmodule

bind sel_vote_filter sel_vote_filter_chk #(.HIST_D(HIST_D), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_out   (filt_out),
    .pass_mode  (pass_mode),
    .sync_lvl   (sync_lvl),
    .mode_q     (mode_q),
    .mode_chg   (mode_chg),
    .shift_en   (shift_en),
    .hist       (hist),
    .all_one    (all_one),
    .all_zero   (all_zero),
    .tap_strobe (tap_strobe),
    .tap_p      (tap_p),
    .tap_q      (tap_q),
    .tap_r      (tap_r)
);

// File: tb/tb_sel_vote_filter.sv
module tb_sel_vote_filter;
    localparam int CNT_W = 24;
    localparam int IDX_W = $clog2(CNT_W);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_in = 1'b0;
    logic [2:0]       mode_sel = 3'b000;
    logic [CNT_W-1:0] sys_count = '0;
    logic [IDX_W-1:0] tap_p = 5'd2;
    logic [IDX_W-1:0] tap_q = 5'd3;
    logic [IDX_W-1:0] tap_r = 5'd4;
    logic             filt_out;

    int    n_chk = 0;
    int    n_fail = 0;
    string req = "R1";
    logic  checking = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    sel_vote_filter dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .mode_sel  (mode_sel),
        .sys_count (sys_count),
        .tap_p     (tap_p),
        .tap_q     (tap_q),
        .tap_r     (tap_r),
        .filt_out  (filt_out)
    );

    always @(negedge clk) sys_count <= sys_count + 1'b1;

    // Behavioural reference model
    int m_s1, m_s2, m_mq, m_out;
    int m_prev[3];
    int hq[$];

    always @(posedge clk) begin : model
        int idx[3];
        int stb[3];
        int b, sstb, nout, d, ones;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_mq = 0; m_out = 0;
            m_prev = '{0, 0, 0};
            hq = '{0, 0, 0, 0};
        end else begin
            idx = '{int'(tap_p), int'(tap_q), int'(tap_r)};
            for (int i = 0; i < 3; i++) begin
                b = (idx[i] < CNT_W) ? int'(sys_count[idx[i]]) : 0;
                stb[i] = (b == 1 && m_prev[i] == 0) ? 1 : 0;
                m_prev[i] = b;
            end
            case (m_mq)
                4: sstb = 1;
                5: sstb = stb[0];
                6: sstb = stb[1];
                7: sstb = stb[2];
                default: sstb = 0;
            endcase
            if (m_mq < 4) begin
                nout = m_s2;
            end else begin
                d = (m_mq == 7) ? 4 : (m_mq == 6) ? 3 : 2;
                ones = 0;
                for (int i = 0; i < d; i++) ones += hq[i];
                nout = (ones == d) ? 1 : (ones == 0) ? 0 : m_out;
            end
            if (int'(mode_sel) != m_mq) begin
                hq = '{m_s2, m_s2, m_s2, m_s2};
            end else if (sstb == 1 && m_mq >= 4) begin
                hq.push_front(m_s2);
                void'(hq.pop_back());
            end
            m_out = nout;
            m_s2 = m_s1;
            m_s1 = int'(pin_in);
            m_mq = int'(mode_sel);
        end
    end

    task automatic advance_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic compare();
        n_chk++;
        if (int'(filt_out) != m_out) begin
            n_fail++;
            $display("FAIL %s: filt_out=%0d expected=%0d at %0t", req, filt_out, m_out, $time);
        end
    endtask

    task automatic tick(input logic p);
        @(negedge clk);
        if (checking) compare();
        pin_in = p;
    endtask

    task automatic runs(input int n, input int maxlen);
        for (int k = 0; k < n; k++) begin
            int len;
            advance_lfsr();
            len = 1 + int'(lfsr[7:2]) % maxlen;
            for (int j = 0; j < len; j++) tick(lfsr[0]);
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_chk++;
        if (filt_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: filt_out=%0d expected=0 in reset", filt_out);
        end
        rst_n = 1'b1;
        checking = 1'b1;
        repeat (4) tick(1'b0);

        // R2: pass mode and reserved codes
        req = "R2"; mode_sel = 3'b000; runs(40, 4);
        mode_sel = 3'b001; runs(15, 4);
        mode_sel = 3'b011; runs(15, 4);

        // R3: 2-of-2 every clock, single-cycle spikes and clk/2 toggling
        req = "R3"; mode_sel = 3'b100;
        repeat (6) tick(1'b0);
        for (int k = 0; k < 10; k++) begin
            tick(1'b1);
            repeat (4) tick(1'b0);
        end
        for (int k = 0; k < 20; k++) begin
            repeat (2) tick(1'b1);
            repeat (2) tick(1'b0);
        end
        runs(40, 3);

        // R4: 2-of-2 on P strobe
        req = "R4"; mode_sel = 3'b101; tap_p = 5'd2; runs(60, 20);

        // R5: 3-of-3 on Q strobe
        req = "R5"; mode_sel = 3'b110; tap_q = 5'd3; runs(60, 40);

        // R6: 4-of-4 on R strobe
        req = "R6"; mode_sel = 3'b111; tap_r = 5'd4; runs(60, 60);

        // R7: bouncy edges that leave mixed windows
        req = "R7"; mode_sel = 3'b110; tap_q = 5'd2; runs(150, 6);

        // R10: short glitches between strobes on a slow tap
        req = "R10"; mode_sel = 3'b111; tap_r = 5'd5;
        for (int k = 0; k < 12; k++) begin
            repeat (200) tick(1'b1);
            repeat (5) begin
                tick(1'b0);
                repeat (6) tick(1'b1);
            end
            repeat (200) tick(1'b0);
        end

        // R8: other tap bits, and an index beyond the counter width
        req = "R8"; mode_sel = 3'b101; tap_p = 5'd0; runs(40, 5);
        tap_p = 5'd31; runs(40, 8);

        // R9: mode changes, many of them on strobe cycles
        req = "R9"; tap_p = 5'd1; tap_q = 5'd2; tap_r = 5'd3;
        for (int k = 0; k < 80; k++) begin
            advance_lfsr();
            mode_sel = lfsr[3] ? {1'b1, lfsr[5:4]} : 3'b100;
            if (lfsr[9:8] == 2'b00) mode_sel = 3'b000;
            runs(1 + int'(lfsr[11:10]), 5);
        end

        req = "R1";
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL %s: watchdog expired, actual=hung expected=done", req);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule